// File: doc/BRIEF.md
# Twofish Encryption Pipeline

This block encrypts 128-bit data blocks with the Twofish cipher. Its datapath is fully unrolled: input whitening and each of the sixteen Feistel rounds has its own pipeline register. A new plaintext block can enter on every clock, and the matching ciphertext leaves a fixed number of advancing clocks later. The round subkeys and the key-dependent S-box words are computed elsewhere, ahead of time. A key store presents them on static input buses and holds them steady while blocks are in flight.

Each round applies the g function to two of the four 32-bit words. The g function is the key-dependent byte permutations followed by an MDS matrix multiply. The two results are mixed by a pseudo-Hadamard transform, their round subkeys are added, and they are folded into the other two words with one-bit rotations. The word pairs then swap. One downstream ready signal stalls every stage at once, and it is passed back upstream as the input ready, so no block is dropped or duplicated when the consumer pauses.

Top module: `twofish_pipe`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid_o` is 0.
- R2: Byte n of a block sits at bits [8n+7:8n], and word i sits at bits [32i+31:32i]. Subkey word j sits at `subkey_i[32j+31:32j]`. Words 0..3 of the input are XORed with subkeys 0..3 before the first round. After the last round, the final word-pair swap is undone and the words are XORed with subkeys 4..7.
- R3: In round r (0..15), with T0 = g(word0) and T1 = g(word1 rotated left 8): word2 becomes ror1(word2 ^ (T0+T1+K[2r+8])), and word3 becomes rol1(word3) ^ (T0+2*T1+K[2r+9]). All sums are modulo 2^32. The pairs (0,1) and (2,3) then swap.
- R4: g is the Twofish h function keyed by the list L0..L(KEY_WORDS-1), where Lj is `sbox_key_i[32j+31:32j]`. KEY_WORDS ranges from 2 to 4, matching keys of 128 to 256 bits.
- R5: A block taken on a clock edge (`in_valid_i` and `in_ready_o` both high) appears on `out_block_o`, with `out_valid_o` high, after exactly 17 further edges on which `out_ready_i` was high.
- R6: With `out_ready_i` held high, blocks are accepted and delivered one per cycle back to back, with up to 17 in flight.
- R7: On an edge where `out_ready_i` is low, every stage holds: `out_block_o` and `out_valid_o` keep their values.
- R8: `in_ready_o` follows `out_ready_i`. A block offered while stalled is not taken, and the source must keep offering it.
- R9: Every output corresponds to exactly one accepted block. An idle input cycle yields an empty slot, not an output.
- R10: With all subkeys and S-box words derived from an all-zero 128-bit key, an all-zero plaintext encrypts to bytes 9F 58 9F 5C F6 12 2C 32 B6 BF EC 2F 2A E8 C3 5A, with byte 0 first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid_i | input | 1 | Plaintext block offered |
| in_ready_o | output | 1 | Pipeline can take a block this cycle |
| in_block_i | input | 128 | Plaintext block |
| subkey_i | input | 32*(2*ROUNDS+8) | Expanded subkeys from the key store, word j at [32j+31:32j] |
| sbox_key_i | input | 32*KEY_WORDS | Key-dependent S-box words L0..L(KEY_WORDS-1) |
| out_valid_o | output | 1 | Ciphertext block present |
| out_ready_i | input | 1 | Consumer takes the block; low stalls the whole pipeline |
| out_block_o | output | 128 | Ciphertext block |

## Verification
Two events can fall in the same cycle: a new block being offered and a stall from the consumer. On such an edge the block must stay outside the pipe while everything already inside freezes. The second case is an accept and an emit on the same edge. The bench provokes both with random valid and ready patterns and with a directed run in which a block is offered during several stalled cycles. A reference model computes the expected ciphertext of each accepted block, and the bench compares it with the output. It also counts the advancing edges between entry and exit to confirm that a stall neither loses a block nor shifts the latency.

// File: rtl/tf_pkg.sv
package tf_pkg;

  typedef logic [3:0][31:0] tf_quad_t;

  function automatic logic [31:0] tf_rol(logic [31:0] v, int n);
    return (v << n) | (v >> (32 - n));
  endfunction

  function automatic logic [31:0] tf_ror(logic [31:0] v, int n);
    return (v >> n) | (v << (32 - n));
  endfunction

  // nibble table t of permutation sel, entry idx stored at bits [4*idx+3:4*idx]
  function automatic logic [3:0] tf_nib(logic sel, logic [1:0] t, logic [3:0] idx);
    logic [63:0] tab;
    case ({sel, t})
      3'b000:  tab = 64'h4ACE95B023F6D718;
      3'b001:  tab = 64'hD9076A4F53218BCE;
      3'b010:  tab = 64'h17423F8C09D6E5AB;
      3'b011:  tab = 64'hAC5803B9E6214F7D;
      3'b100:  tab = 64'h5CA04913E67FDB82;
      3'b101:  tab = 64'h809F5AD673C4B2E1;
      3'b110:  tab = 64'hF3B28DE0A96157C4;
      default: tab = 64'hA802F746ED3C159B;
    endcase
    return tab[{idx, 2'b00} +: 4];
  endfunction

  // fixed byte permutation q0 (sel=0) or q1 (sel=1)
  function automatic logic [7:0] tf_q(logic sel, logic [7:0] x);
    logic [3:0] a0, b0, a1, b1, a2, b2, a3, b3, a4, b4;
    a0 = x[7:4];
    b0 = x[3:0];
    a1 = a0 ^ b0;
    b1 = a0 ^ {b0[0], b0[3:1]} ^ {a0[0], 3'b000};
    a2 = tf_nib(sel, 2'd0, a1);
    b2 = tf_nib(sel, 2'd1, b1);
    a3 = a2 ^ b2;
    b3 = a2 ^ {b2[0], b2[3:1]} ^ {a2[0], 3'b000};
    a4 = tf_nib(sel, 2'd2, a3);
    b4 = tf_nib(sel, 2'd3, b3);
    return {b4, a4};
  endfunction

  // GF(2^8) product, field polynomial x^8+x^6+x^5+x^3+1
  function automatic logic [7:0] tf_gmul(logic [7:0] a, logic [7:0] b);
    logic [7:0] p, x;
    p = '0;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = x[7] ? ((x << 1) ^ 8'h69) : (x << 1);
    end
    return p;
  endfunction

  // MDS row i, coefficient for input byte j at bits [8j+7:8j]
  function automatic logic [31:0] tf_mds_row(int i);
    case (i)
      0:       return 32'h5B5BEF01;
      1:       return 32'h01EFEF5B;
      2:       return 32'hEF015BEF;
      default: return 32'h5BEF01EF;
    endcase
  endfunction

  function automatic logic [31:0] tf_mds(logic [3:0][7:0] y);
    logic [3:0][7:0] z;
    logic [31:0] row;
    z = '0;
    for (int i = 0; i < 4; i++) begin
      row = tf_mds_row(i);
      for (int j = 0; j < 4; j++) z[i] = z[i] ^ tf_gmul(row[8*j +: 8], y[j]);
    end
    return z;
  endfunction

  // keyed h function; l[0..kw-1] are the key list words
  function automatic logic [31:0] tf_h(logic [31:0] x, tf_quad_t l, int kw);
    logic [3:0][7:0] y;
    y = x;
    if (kw == 4) begin
      y[0] = tf_q(1'b1, y[0]) ^ l[3][7:0];
      y[1] = tf_q(1'b0, y[1]) ^ l[3][15:8];
      y[2] = tf_q(1'b0, y[2]) ^ l[3][23:16];
      y[3] = tf_q(1'b1, y[3]) ^ l[3][31:24];
    end
    if (kw >= 3) begin
      y[0] = tf_q(1'b1, y[0]) ^ l[2][7:0];
      y[1] = tf_q(1'b1, y[1]) ^ l[2][15:8];
      y[2] = tf_q(1'b0, y[2]) ^ l[2][23:16];
      y[3] = tf_q(1'b0, y[3]) ^ l[2][31:24];
    end
    y[0] = tf_q(1'b1, tf_q(1'b0, tf_q(1'b0, y[0]) ^ l[1][7:0])   ^ l[0][7:0]);
    y[1] = tf_q(1'b0, tf_q(1'b0, tf_q(1'b1, y[1]) ^ l[1][15:8])  ^ l[0][15:8]);
    y[2] = tf_q(1'b1, tf_q(1'b1, tf_q(1'b0, y[2]) ^ l[1][23:16]) ^ l[0][23:16]);
    y[3] = tf_q(1'b0, tf_q(1'b1, tf_q(1'b1, y[3]) ^ l[1][31:24]) ^ l[0][31:24]);
    return tf_mds(y);
  endfunction

  // pseudo-Hadamard mix plus round keys: {F1, F0}
  function automatic logic [63:0] tf_pht(logic [31:0] t0, logic [31:0] t1,
                                         logic [31:0] ke, logic [31:0] ko);
    logic [31:0] f0, f1;
    f0 = t0 + t1 + ke;
    f1 = t0 + (t1 << 1) + ko;
    return {f1, f0};
  endfunction

endpackage

// File: rtl/tf_gfunc.sv
module tf_gfunc
  import tf_pkg::*;
#(
  parameter int KEY_WORDS = 2
) (
  input  logic [31:0]             x_i,
  input  logic [32*KEY_WORDS-1:0] sk_i,
  output logic [31:0]             y_o
);

  tf_quad_t lst;

  always_comb begin
    lst = '0;
    for (int i = 0; i < KEY_WORDS; i++) lst[i] = sk_i[32*i +: 32];
    y_o = tf_h(x_i, lst, KEY_WORDS);
  end

endmodule

// File: rtl/tf_round.sv
module tf_round
  import tf_pkg::*;
#(
  parameter int KEY_WORDS = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    vld_i,
  input  tf_quad_t                st_i,
  input  logic [31:0]             k_even_i,
  input  logic [31:0]             k_odd_i,
  input  logic [32*KEY_WORDS-1:0] sk_i,
  output logic                    vld_o,
  output tf_quad_t                st_o
);

  logic [31:0] t0, t1, f0, f1;
  tf_quad_t    nxt;

  tf_gfunc #(.KEY_WORDS(KEY_WORDS)) u_g0 (
    .x_i (st_i[0]),
    .sk_i(sk_i),
    .y_o (t0)
  );

  tf_gfunc #(.KEY_WORDS(KEY_WORDS)) u_g1 (
    .x_i (tf_rol(st_i[1], 8)),
    .sk_i(sk_i),
    .y_o (t1)
  );

  always_comb begin
    {f1, f0} = tf_pht(t0, t1, k_even_i, k_odd_i);
    nxt[0]   = tf_ror(st_i[2] ^ f0, 1);
    nxt[1]   = tf_rol(st_i[3], 1) ^ f1;
    nxt[2]   = st_i[0];
    nxt[3]   = st_i[1];
  end

  always_ff @(posedge clk) begin
    if (rst)     vld_o <= 1'b0;
    else if (en) vld_o <= vld_i;
  end

  always_ff @(posedge clk) begin
    if (en) st_o <= nxt;
  end

endmodule

// File: rtl/twofish_pipe.sv
module twofish_pipe
  import tf_pkg::*;
#(
  parameter int KEY_WORDS = 2,
  parameter int ROUNDS    = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid_i,
  output logic                          in_ready_o,
  input  logic [127:0]                  in_block_i,
  input  logic [32*(2*ROUNDS+8)-1:0]    subkey_i,
  input  logic [32*KEY_WORDS-1:0]       sbox_key_i,
  output logic                          out_valid_o,
  input  logic                          out_ready_i,
  output logic [127:0]                  out_block_o
);

  localparam int LAT = ROUNDS + 1;

  // named events for the checker
  logic           adv;
  logic           accept;
  logic [LAT-1:0] stage_vld;

  logic           wh_vld;
  tf_quad_t       wh_st, wh_nxt;
  logic           rnd_vld [ROUNDS+1];
  tf_quad_t       rnd_st  [ROUNDS+1];
  tf_quad_t       fin;

  assign adv        = out_ready_i;
  assign accept     = in_valid_i && adv;
  assign in_ready_o = adv;

  always_comb begin
    for (int i = 0; i < 4; i++) wh_nxt[i] = in_block_i[32*i +: 32] ^ subkey_i[32*i +: 32];
  end

  always_ff @(posedge clk) begin
    if (rst)      wh_vld <= 1'b0;
    else if (adv) wh_vld <= accept;
  end

  always_ff @(posedge clk) begin
    if (adv) wh_st <= wh_nxt;
  end

  assign rnd_vld[0] = wh_vld;
  assign rnd_st[0]  = wh_st;

  for (genvar r = 1; r <= ROUNDS; r++) begin : g_rnd
    tf_round #(.KEY_WORDS(KEY_WORDS)) u_round (
      .clk     (clk),
      .rst     (rst),
      .en      (adv),
      .vld_i   (rnd_vld[r-1]),
      .st_i    (rnd_st[r-1]),
      .k_even_i(subkey_i[32*(2*(r-1)+8) +: 32]),
      .k_odd_i (subkey_i[32*(2*(r-1)+9) +: 32]),
      .sk_i    (sbox_key_i),
      .vld_o   (rnd_vld[r]),
      .st_o    (rnd_st[r])
    );
  end

  for (genvar s = 0; s < LAT; s++) begin : g_vld
    assign stage_vld[s] = rnd_vld[s];
  end

  // undo the last swap, then output whitening with subkeys 4..7
  always_comb begin
    fin[0] = rnd_st[ROUNDS][2] ^ subkey_i[32*4 +: 32];
    fin[1] = rnd_st[ROUNDS][3] ^ subkey_i[32*5 +: 32];
    fin[2] = rnd_st[ROUNDS][0] ^ subkey_i[32*6 +: 32];
    fin[3] = rnd_st[ROUNDS][1] ^ subkey_i[32*7 +: 32];
  end

  assign out_block_o = fin;
  assign out_valid_o = rnd_vld[ROUNDS];

endmodule

// File: rtl/tf_pipe_chk.sv
module tf_pipe_chk #(
  parameter int LAT = 17
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid_i,
  input logic           in_ready_o,
  input logic           out_valid_o,
  input logic           out_ready_i,
  input logic [127:0]   out_block_o,
  input logic [LAT-1:0] stage_vld
);

  localparam int CW = $clog2(LAT + 1) + 1;

  logic [CW-1:0] inflight;

  always_ff @(posedge clk) begin
    if (rst) inflight <= '0;
    else     inflight <= inflight + CW'(in_valid_i && in_ready_o) - CW'(out_valid_o && out_ready_i);
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !out_ready_i |=> $stable(out_block_o) && $stable(out_valid_o)); // R7

  AST_PIPE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !out_ready_i |=> $stable(stage_vld)); // R7

  AST_OCCUPANCY: assert property (@(posedge clk) disable iff (rst)
    $countones(stage_vld) == inflight); // R6

  AST_CAPACITY: assert property (@(posedge clk) disable iff (rst)
    inflight <= CW'(LAT)); // R6

  AST_OUT_NEEDS_INPUT: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |-> inflight != '0); // R9

endmodule

bind twofish_pipe tf_pipe_chk #(.LAT(LAT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .out_block_o(out_block_o),
  .stage_vld  (stage_vld)
);

// File: tb/tb_twofish_pipe.sv
`timescale 1ns/1ps
module tb_twofish_pipe;

  localparam int KW  = 2;
  localparam int NR  = 16;
  localparam int NSK = 2*NR + 8;
  localparam int LAT = NR + 1;
  localparam logic [127:0] KAT_CT = 128'h5AC3E82A2FECBFB6322C12F65C9F589F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [127:0] in_block = '0;
  logic [32*NSK-1:0] sk = '0;
  logic [32*KW-1:0]  sbk = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [127:0] out_block;

  always #5 clk = ~clk;

  twofish_pipe #(.KEY_WORDS(KW), .ROUNDS(NR)) dut (
    .clk(clk), .rst(rst), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_block_i(in_block), .subkey_i(sk), .sbox_key_i(sbk),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_block_o(out_block)
  );

  // ---------------- reference model ----------------
  localparam int QA0 [16] = '{8,1,7,13,6,15,3,2,0,11,5,9,14,12,10,4};
  localparam int QA1 [16] = '{14,12,11,8,1,2,3,5,15,4,10,6,7,0,9,13};
  localparam int QA2 [16] = '{11,10,5,14,6,13,9,0,12,8,15,3,2,4,7,1};
  localparam int QA3 [16] = '{13,7,15,4,1,2,6,14,9,11,3,0,8,5,12,10};
  localparam int QB0 [16] = '{2,8,11,13,15,7,6,14,3,1,9,4,0,10,12,5};
  localparam int QB1 [16] = '{1,14,2,11,4,12,3,7,6,13,10,5,15,9,0,8};
  localparam int QB2 [16] = '{4,12,7,5,1,6,9,10,0,14,13,8,2,11,3,15};
  localparam int QB3 [16] = '{11,9,5,1,12,3,13,14,6,4,7,15,2,0,8,10};
  localparam int MD [4][4] = '{'{8'h01,8'hEF,8'h5B,8'h5B}, '{8'h5B,8'hEF,8'hEF,8'h01},
                               '{8'hEF,8'h5B,8'h01,8'hEF}, '{8'hEF,8'h01,8'hEF,8'h5B}};

  function automatic int b_t(int sel, int t, int i);
    if (sel == 0) case (t) 0: return QA0[i]; 1: return QA1[i]; 2: return QA2[i]; default: return QA3[i]; endcase
    else          case (t) 0: return QB0[i]; 1: return QB1[i]; 2: return QB2[i]; default: return QB3[i]; endcase
  endfunction

  function automatic logic [7:0] b_q(int sel, logic [7:0] x);
    int a, b, a1, b1, a2, b2, a3, b3;
    a = int'(x) >> 4; b = int'(x) & 15;
    a1 = a ^ b;  b1 = a ^ (((b >> 1) | (b << 3)) & 15) ^ ((a * 8) & 15);
    a2 = b_t(sel, 0, a1); b2 = b_t(sel, 1, b1);
    a3 = a2 ^ b2; b3 = a2 ^ (((b2 >> 1) | (b2 << 3)) & 15) ^ ((a2 * 8) & 15);
    return 8'(b_t(sel, 3, b3) * 16 + b_t(sel, 2, a3));
  endfunction

  function automatic logic [7:0] b_gmul(logic [7:0] a, logic [7:0] b);
    logic [14:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (15'(a) << i);
    for (int i = 14; i >= 8; i--) if (p[i]) p = p ^ (15'(9'h169) << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [31:0] b_h(logic [31:0] x, logic [3:0][31:0] l, int kw);
    logic [7:0] y [4];
    logic [31:0] z;
    logic [3:0] s4, s3, sa, sb, sc;
    s4 = 4'b1001; s3 = 4'b0011; sa = 4'b1010; sb = 4'b1100; sc = 4'b0101;
    for (int j = 0; j < 4; j++) begin
      y[j] = x[8*j +: 8];
      if (kw == 4) y[j] = b_q(int'(s4[j]), y[j]) ^ l[3][8*j +: 8];
      if (kw >= 3) y[j] = b_q(int'(s3[j]), y[j]) ^ l[2][8*j +: 8];
      y[j] = b_q(int'(sa[j]), y[j]) ^ l[1][8*j +: 8];
      y[j] = b_q(int'(sb[j]), y[j]) ^ l[0][8*j +: 8];
      y[j] = b_q(int'(sc[j]), y[j]);
    end
    z = '0;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) z[8*i +: 8] = z[8*i +: 8] ^ b_gmul(8'(MD[i][j]), y[j]);
    return z;
  endfunction

  function automatic logic [31:0] rl(logic [31:0] v, int n);
    return (v << n) | (v >> (32 - n));
  endfunction

  function automatic logic [31:0] b_g(logic [31:0] x);
    logic [3:0][31:0] l;
    l = '0;
    for (int j = 0; j < KW; j++) l[j] = sbk[32*j +: 32];
    return b_h(x, l, KW);
  endfunction

  function automatic logic [31:0] kw_of(int i);
    return sk[32*i +: 32];
  endfunction

  function automatic logic [127:0] b_enc(logic [127:0] pt);
    logic [31:0] w0, w1, w2, w3, t0, t1, a, b;
    w0 = pt[31:0] ^ kw_of(0);   w1 = pt[63:32] ^ kw_of(1);
    w2 = pt[95:64] ^ kw_of(2);  w3 = pt[127:96] ^ kw_of(3);
    for (int r = 0; r < NR; r++) begin
      t0 = b_g(w0);
      t1 = b_g(rl(w1, 8));
      w2 = rl(w2 ^ (t0 + t1 + kw_of(2*r+8)), 31);
      w3 = rl(w3, 1) ^ (t0 + 2*t1 + kw_of(2*r+9));
      if (r < NR - 1) begin
        a = w0; b = w1; w0 = w2; w1 = w3; w2 = a; w3 = b;
      end
    end
    return {w3 ^ kw_of(7), w2 ^ kw_of(6), w1 ^ kw_of(5), w0 ^ kw_of(4)};
  endfunction

  // subkeys of an all-zero 128-bit key
  task automatic load_zero_key();
    logic [3:0][31:0] m;
    logic [31:0] a, b;
    m = '0;
    for (int i = 0; i < NSK/2; i++) begin
      a = b_h(32'(2*i) * 32'h01010101, m, 2);
      b = rl(b_h(32'(2*i+1) * 32'h01010101, m, 2), 8);
      sk[32*(2*i) +: 32]   = a + b;
      sk[32*(2*i+1) +: 32] = rl(a + 2*b, 9);
    end
    sbk = '0;
  endtask

  // ---------------- scoreboard ----------------
  int n_chk = 0, n_fail = 0;
  int head = 0, tail = 0, tick = 0;
  logic [127:0] exp_q [1024];
  int           tk_q  [1024];
  logic         prev_rdy = 1'b1;
  logic [127:0] held_blk = '0;
  logic         held_vld = 1'b0;
  logic [127:0] last_pop = '0;
  string        tag = "R2";
  bit           done = 0;

  task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic iv, input logic [127:0] d, input logic rdy);
    @(negedge clk);
    if (!prev_rdy) begin
      chk(out_block == held_blk, "R7", "data held in stall", out_block, held_blk);
      chk(out_valid == held_vld, "R7", "valid held in stall", 128'(out_valid), 128'(held_vld));
    end
    in_valid = iv; in_block = d; out_ready = rdy;
    #1;
    chk(in_ready == rdy, "R8", "in_ready mirrors out_ready", 128'(in_ready), 128'(rdy));
    if (out_valid && rdy) begin
      if (head == tail) chk(1'b0, "R9", "output with nothing accepted", out_block, '0);
      else begin
        chk(out_block == exp_q[head % 1024], tag, "ciphertext", out_block, exp_q[head % 1024]);
        chk(tick - tk_q[head % 1024] == LAT, "R5", "latency in advancing edges",
            128'(tick - tk_q[head % 1024]), 128'(LAT));
        last_pop = out_block;
        head++;
      end
    end
    if (iv && in_ready) begin
      exp_q[tail % 1024] = b_enc(d);
      tk_q[tail % 1024]  = tick;
      tail++;
    end
    if (rdy) tick++;
    held_blk = out_block; held_vld = out_valid; prev_rdy = rdy;
  endtask

  task automatic drain();
    for (int g = 0; g < 3*LAT && head != tail; g++) step(1'b0, '0, 1'b1);
    chk(head == tail, "R9", "every accepted block delivered", 128'(tail - head), '0);
    step(1'b0, '0, 1'b1);
    chk(out_valid == 1'b0, "R9", "no output once drained", 128'(out_valid), '0);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    void'($urandom(32'd2013));
    load_zero_key();
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "valid low in reset", 128'(out_valid), '0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "valid low after reset", 128'(out_valid), '0);

    // known answer, zero key
    tag = "R2";
    step(1'b1, '0, 1'b1);
    drain();
    chk(last_pop == KAT_CT, "R10", "zero-key known answer", last_pop, KAT_CT);

    // back-to-back stream with zero key
    tag = "R6";
    for (int i = 0; i < 40; i++) step(1'b1, rnd128(), 1'b1);
    drain();

    // random subkeys, random valid and ready
    tag = "R3";
    for (int i = 0; i < NSK; i++) sk[32*i +: 32] = $urandom;
    for (int i = 0; i < 250; i++) step(($urandom % 4) != 0, rnd128(), ($urandom % 4) != 0);
    drain();

    // random S-box words, directed stall while offering
    tag = "R4";
    sbk = {$urandom, $urandom};
    for (int i = 0; i < 20; i++) step(1'b1, rnd128(), 1'b1);
    begin
      logic [127:0] held_in;
      held_in = rnd128();
      for (int i = 0; i < 4; i++) step(1'b1, held_in, 1'b0);
      step(1'b1, held_in, 1'b1);
    end
    for (int i = 0; i < 250; i++) step(($urandom % 3) != 0, rnd128(), ($urandom % 3) != 0);
    for (int i = 0; i < 6; i++) step(1'b0, '0, 1'b1);
    drain();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule